// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Decoder

This block sits on the device side of a serial flash memory. It watches the SPI pins in mode 0 (clock idles low, data sampled on the rising clock edge, most significant bit first). It recognises the three commands that erase a block of the array to all ones. After the command byte it collects a 24-bit address, sent most significant byte first. It waits for the chip select to be released and then decides whether the command was well formed.

When the command ends cleanly and the externally held write-enable latch is set, the block raises a request for one system-clock cycle. The request carries the block base address, with the bits below the block size cleared, and a code for the block size. In the same cycle it pulses a clear to the write-enable latch. The array and the self-timed erase engine consume the request; they are not part of this block. All SPI pins are brought into the system clock domain through synchronisers, and the whole decoder runs on that clock.

Top module: `erase_decoder_top`

## Requirements
- R1: Command byte 20h gives size code 0 (4 KB), 52h gives size code 1 (32 KB) and D8h gives size code 2 (64 KB) on `erase_size_o` with the request.
- R2: Bits on `spi_si_i` are taken on rising edges of `spi_sclk_i` while `spi_cs_n_i` is low, most significant bit first. The three address bytes follow the command byte in order A23–A16, A15–A8, A7–A0.
- R3: `erase_base_o` equals the received address with bits 11..0 cleared for size 0, bits 14..0 for size 1 and bits 15..0 for size 2.
- R4: A request is issued only if `wel_i` is high when the chip-select release is seen. `wel_clr_o` pulses exactly once, in the same cycle as each request, and never otherwise.
- R5: The request comes only after `spi_cs_n_i` rises. It is exactly one cycle long and appears 3 system clocks after the rise, with the default two synchroniser stages.
- R6: If chip select rises before the third address byte is complete, no request is issued.
- R7: If chip select rises after a bit count that is not a multiple of 8, no request is issued.
- R8: Whole bytes sent after the third address byte are ignored: the request is still issued, with the address from the first three bytes.
- R9: A command byte other than the three erase codes makes the decoder ignore every later byte until chip select rises, so no request follows.
- R10: Chip select high clears the bit counter and command state, so a transaction after an aborted one is decoded from its first bit.
- R11: After reset, `erase_req_o` and `wel_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock, asynchronous to clk |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_si_i | input | 1 | SPI serial data into the device |
| wel_i | input | 1 | Current value of the write-enable latch |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_base_o | output | 24 | Block-aligned base address, valid with the request |
| erase_size_o | output | 2 | Block size code, valid with the request |
| wel_clr_o | output | 1 | One-cycle clear for the write-enable latch |

## Verification
Each pin is seen two clocks after it changes, so a chip-select release produces a request on the third system clock after the pin rises. The bench records the cycle of every release and the cycle of every request pulse. It checks that the difference is exactly three and that exactly one pulse occurred. Serial bits are held for four system clocks per clock phase, so each edge passes the synchroniser well before the next one. Results are read only after a settle window of twelve cycles past the release, on falling clock edges.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    // Block size code carried with an erase request
    typedef enum logic [1:0] {
        BLK_4K  = 2'd0,
        BLK_32K = 2'd1,
        BLK_64K = 2'd2
    } blk_size_e;

    // Command bytes that select a block erase
    localparam logic [7:0] OPC_ERASE_4K  = 8'h20;
    localparam logic [7:0] OPC_ERASE_32K = 8'h52;
    localparam logic [7:0] OPC_ERASE_64K = 8'hD8;

    // Decoder phase within one chip-select window
    typedef enum logic [1:0] {
        CMD_OPCODE = 2'd0,
        CMD_ADDR   = 2'd1,
        CMD_ARMED  = 2'd2,
        CMD_SKIP   = 2'd3
    } cmd_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sclk_rise_o,
    output logic cs_active_o,
    output logic cs_rise_o,
    output logic si_o
);

    typedef struct packed {
        logic [STAGES-1:0] sclk_pipe;
        logic [STAGES-1:0] cs_pipe;
        logic [STAGES-1:0] si_pipe;
        logic              sclk_prev;
        logic              cs_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    logic sclk_s;
    logic cs_n_s;

    assign sclk_s = sync_q.sclk_pipe[STAGES-1];
    assign cs_n_s = sync_q.cs_pipe[STAGES-1];

    always_comb begin
        sync_d = sync_q;
        sync_d.sclk_pipe[0] = sclk_i;
        sync_d.cs_pipe[0]   = cs_n_i;
        sync_d.si_pipe[0]   = si_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.sclk_pipe[i] = sync_q.sclk_pipe[i-1];
            sync_d.cs_pipe[i]   = sync_q.cs_pipe[i-1];
            sync_d.si_pipe[i]   = sync_q.si_pipe[i-1];
        end
        sync_d.sclk_prev = sclk_s;
        sync_d.cs_prev   = cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk_pipe <= '0;
            sync_q.cs_pipe   <= '1;
            sync_q.si_pipe   <= '0;
            sync_q.sclk_prev <= 1'b0;
            sync_q.cs_prev   <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sclk_rise_o = sclk_s & ~sync_q.sclk_prev;
    assign cs_active_o = ~cs_n_s;
    assign cs_rise_o   = cs_n_s & ~sync_q.cs_prev;
    assign si_o        = sync_q.si_pipe[STAGES-1];

    // A release edge cannot repeat on back-to-back cycles
    AST_CS_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise_o |=> !cs_rise_o); // R5

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic            bit_stb_i,
    input  logic            bit_i,
    output logic            byte_done_o,
    output logic [BITS-1:0] byte_o,
    output logic            aligned_o
);

    localparam int CNT_W = $clog2(BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BITS-2:0]  shreg;
    } rx_t;

    rx_t rx_d, rx_q;

    logic last_bit;

    assign last_bit = (rx_q.cnt == CNT_W'(BITS - 1));

    always_comb begin
        rx_d = rx_q;
        if (!active_i) begin
            rx_d.cnt   = '0;
            rx_d.shreg = '0;
        end else if (bit_stb_i) begin
            rx_d.shreg = {rx_q.shreg[BITS-3:0], bit_i};
            rx_d.cnt   = last_bit ? '0 : rx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    // The completed byte is presented in the cycle of its last bit
    assign byte_done_o = active_i & bit_stb_i & last_bit;
    assign byte_o      = {rx_q.shreg, bit_i};
    assign aligned_o   = (rx_q.cnt == '0);

    AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (rx_q.cnt == '0)); // R10

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && bit_stb_i && !last_bit) |=> (rx_q.cnt != '0)); // R7

endmodule

// File: rtl/erase_cmd_fsm.sv
module erase_cmd_fsm
    import spi_erase_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LOW_4K  = 12,
    parameter int LOW_32K = 15,
    parameter int LOW_64K = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              byte_done_i,
    input  logic [7:0]        byte_i,
    input  logic              cs_rise_i,
    input  logic              aligned_i,
    input  logic              wel_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] base_o,
    output blk_size_e         size_o,
    output logic              wel_clr_o
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        cmd_state_e        st;
        logic [IDX_W-1:0]  idx;
        blk_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic              clr;
        logic [ADDR_W-1:0] base;
        blk_size_e         out_size;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    function automatic logic [ADDR_W-1:0] blk_mask(blk_size_e s);
        logic [ADDR_W-1:0] m;
        int                low;
        case (s)
            BLK_4K:  low = LOW_4K;
            BLK_32K: low = LOW_32K;
            default: low = LOW_64K;
        endcase
        m = '1;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < low) m[i] = 1'b0;
        end
        return m;
    endfunction

    logic fire;

    assign fire = cs_rise_i && (fsm_q.st == CMD_ARMED) && aligned_i && wel_i;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.req = 1'b0;
        fsm_d.clr = 1'b0;

        if (fire) begin
            fsm_d.req      = 1'b1;
            fsm_d.clr      = 1'b1;
            fsm_d.base     = fsm_q.addr & blk_mask(fsm_q.size);
            fsm_d.out_size = fsm_q.size;
        end

        if (!active_i) begin
            fsm_d.st   = CMD_OPCODE;
            fsm_d.idx  = '0;
            fsm_d.size = BLK_4K;
            fsm_d.addr = '0;
        end else if (byte_done_i) begin
            case (fsm_q.st)
                CMD_OPCODE: begin
                    fsm_d.idx = '0;
                    case (byte_i)
                        OPC_ERASE_4K: begin
                            fsm_d.size = BLK_4K;
                            fsm_d.st   = CMD_ADDR;
                        end
                        OPC_ERASE_32K: begin
                            fsm_d.size = BLK_32K;
                            fsm_d.st   = CMD_ADDR;
                        end
                        OPC_ERASE_64K: begin
                            fsm_d.size = BLK_64K;
                            fsm_d.st   = CMD_ADDR;
                        end
                        default: fsm_d.st = CMD_SKIP;
                    endcase
                end
                CMD_ADDR: begin
                    fsm_d.addr = {fsm_q.addr[ADDR_W-9:0], byte_i};
                    if (fsm_q.idx == IDX_W'(ADDR_BYTES - 1)) begin
                        fsm_d.st = CMD_ARMED;
                    end else begin
                        fsm_d.idx = fsm_q.idx + 1'b1;
                    end
                end
                default: fsm_d.st = fsm_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st       <= CMD_OPCODE;
            fsm_q.idx      <= '0;
            fsm_q.size     <= BLK_4K;
            fsm_q.addr     <= '0;
            fsm_q.req      <= 1'b0;
            fsm_q.clr      <= 1'b0;
            fsm_q.base     <= '0;
            fsm_q.out_size <= BLK_4K;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign req_o     = fsm_q.req;
    assign wel_clr_o = fsm_q.clr;
    assign base_o    = fsm_q.base;
    assign size_o    = fsm_q.out_size;

    AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == CMD_SKIP && active_i) |=> (fsm_q.st == CMD_SKIP)); // R9

    AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == CMD_ARMED && active_i) |=> (fsm_q.st == CMD_ARMED)); // R8

    AST_IDLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (fsm_q.st == CMD_OPCODE)); // R10

endmodule

// File: rtl/erase_decoder_top.sv
module erase_decoder_top
    import spi_erase_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_4K      = 12,
    parameter int LOW_32K     = 15,
    parameter int LOW_64K     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_si_i,
    input  logic              wel_i,
    output logic              erase_req_o,
    output logic [ADDR_W-1:0] erase_base_o,
    output logic [1:0]        erase_size_o,
    output logic              wel_clr_o
);

    logic      sclk_rise;
    logic      cs_active;
    logic      cs_rise;
    logic      si_s;
    logic      byte_done;
    logic [7:0] rx_byte;
    logic      aligned;
    blk_size_e size_e;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk_i),
        .cs_n_i      (spi_cs_n_i),
        .si_i        (spi_si_i),
        .sclk_rise_o (sclk_rise),
        .cs_active_o (cs_active),
        .cs_rise_o   (cs_rise),
        .si_o        (si_s)
    );

    spi_byte_rx #(
        .BITS (8)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (cs_active),
        .bit_stb_i   (sclk_rise),
        .bit_i       (si_s),
        .byte_done_o (byte_done),
        .byte_o      (rx_byte),
        .aligned_o   (aligned)
    );

    erase_cmd_fsm #(
        .ADDR_W  (ADDR_W),
        .LOW_4K  (LOW_4K),
        .LOW_32K (LOW_32K),
        .LOW_64K (LOW_64K)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (cs_active),
        .byte_done_i (byte_done),
        .byte_i      (rx_byte),
        .cs_rise_i   (cs_rise),
        .aligned_i   (aligned),
        .wel_i       (wel_i),
        .req_o       (erase_req_o),
        .base_o      (erase_base_o),
        .size_o      (size_e),
        .wel_clr_o   (wel_clr_o)
    );

    assign erase_size_o = size_e;

    AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> $past(cs_rise)); // R5

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |=> !erase_req_o); // R5

    AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> $past(wel_i)); // R4

    AST_CLR_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> $past(wel_i) && $past(cs_rise)); // R4

    AST_BASE_4K_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_size_o == BLK_4K) |-> (erase_base_o[LOW_4K-1:0] == '0)); // R3

    AST_BASE_64K_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_size_o == BLK_64K) |-> (erase_base_o[LOW_64K-1:0] == '0)); // R3

endmodule

// File: tb/erase_decoder_top_tb_top.sv
module erase_decoder_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int LATENCY    = 3;
    localparam int SETTLE     = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        wel = 1'b0;
    logic        erase_req;
    logic [23:0] erase_base;
    logic [1:0]  erase_size;
    logic        wel_clr;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int req_cnt = 0;
    int clr_cnt = 0;
    int last_req_cyc = 0;
    int rise_cyc = 0;
    logic [23:0] last_base = '0;
    logic [1:0]  last_size = '0;

    erase_decoder_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk_i   (sclk),
        .spi_cs_n_i   (cs_n),
        .spi_si_i     (si),
        .wel_i        (wel),
        .erase_req_o  (erase_req),
        .erase_base_o (erase_base),
        .erase_size_o (erase_size),
        .wel_clr_o    (wel_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && erase_req) begin
            req_cnt      = req_cnt + 1;
            last_base    = erase_base;
            last_size    = erase_size;
            last_req_cyc = cyc;
        end
        if (rst_n && wel_clr) clr_cnt = clr_cnt + 1;
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sclk = 1'b0;
            si   = v[i];
            wait_neg(HALF_SCK);
            sclk = 1'b1;
            wait_neg(HALF_SCK);
        end
    endtask

    task automatic spi_begin();
        wait_neg(1);
        sclk = 1'b0;
        cs_n = 1'b0;
        wait_neg(HALF_SCK);
    endtask

    task automatic spi_end();
        sclk = 1'b0;
        wait_neg(HALF_SCK);
        cs_n     = 1'b1;
        rise_cyc = cyc;
        wait_neg(SETTLE);
    endtask

    function automatic logic [1:0] size_of(logic [7:0] opc);
        case (opc)
            8'h20:   return 2'd0;
            8'h52:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [23:0] aligned_of(logic [23:0] a, logic [1:0] s);
        int low;
        low = (s == 2'd0) ? 12 : (s == 2'd1) ? 15 : 16;
        return (a >> low) << low;
    endfunction

    // Checks request and clear counts, and on a request its fields and latency
    task automatic expect_result(string tag, int r0, int c0, int exp_req,
                                 logic [23:0] addr, logic [7:0] opc);
        chk(tag, "request count", req_cnt - r0, exp_req);
        chk(tag, "latch clear count", clr_cnt - c0, exp_req);
        if (exp_req == 1) begin
            chk(tag, "size code", last_size, size_of(opc));
            chk(tag, "base address", last_base, aligned_of(addr, size_of(opc)));
            chk(tag, "release-to-request cycles", last_req_cyc - rise_cyc, LATENCY);
        end
    endtask

    task automatic run_erase(string tag, logic [7:0] opc, logic [23:0] addr,
                             logic wel_v, int n_addr, int extra_bytes,
                             int extra_bits, int exp_req);
        int r0;
        int c0;
        r0  = req_cnt;
        c0  = clr_cnt;
        wel = wel_v;
        spi_begin();
        spi_bits(opc, 8);
        for (int i = 0; i < n_addr; i++) spi_bits(addr[23-8*i -: 8], 8);
        for (int i = 0; i < extra_bytes; i++) spi_bits(8'hFF, 8);
        if (extra_bits > 0) spi_bits(8'hA5, extra_bits);
        spi_end();
        expect_result(tag, r0, c0, exp_req, addr, opc);
    endtask

    task automatic test_reset();
        chk("R11", "request after reset", erase_req, 0);
        chk("R11", "latch clear after reset", wel_clr, 0);
    endtask

    task automatic test_sizes();
        // R1 R2 R3 R5: all three sizes, varied address patterns
        run_erase("R1", 8'h20, 24'h12ABCD, 1'b1, 3, 0, 0, 1);
        run_erase("R3", 8'h52, 24'h3FFFFF, 1'b1, 3, 0, 0, 1);
        run_erase("R2", 8'hD8, 24'hA5C3E1, 1'b1, 3, 0, 0, 1);
        run_erase("R5", 8'h20, 24'h800FFF, 1'b1, 3, 0, 0, 1);
    endtask

    task automatic test_no_wel();
        run_erase("R4", 8'hD8, 24'h654321, 1'b0, 3, 0, 0, 0);
    endtask

    task automatic test_short_address();
        run_erase("R6", 8'h52, 24'h111111, 1'b1, 2, 0, 0, 0);
        run_erase("R6", 8'h20, 24'h222222, 1'b1, 0, 0, 0, 0);
    endtask

    task automatic test_ragged();
        run_erase("R7", 8'h20, 24'h0F0F0F, 1'b1, 3, 0, 5, 0);
        run_erase("R7", 8'hD8, 24'hF0F0F0, 1'b1, 3, 1, 1, 0);
    endtask

    task automatic test_trailing_bytes();
        run_erase("R8", 8'h52, 24'h5A5A5A, 1'b1, 3, 2, 0, 1);
    endtask

    task automatic test_bad_opcode();
        int r0;
        int c0;
        r0  = req_cnt;
        c0  = clr_cnt;
        wel = 1'b1;
        spi_begin();
        spi_bits(8'h03, 8);
        spi_bits(8'h20, 8);
        spi_bits(8'h12, 8);
        spi_bits(8'h34, 8);
        spi_bits(8'h56, 8);
        spi_end();
        chk("R9", "request count after unknown command", req_cnt - r0, 0);
        chk("R9", "latch clear after unknown command", clr_cnt - c0, 0);
    endtask

    task automatic test_restart();
        int r0;
        int c0;
        wel = 1'b1;
        // Aborted partial opcode, then a full command decoded from its first bit
        spi_begin();
        spi_bits(8'hD8, 4);
        spi_end();
        r0 = req_cnt;
        c0 = clr_cnt;
        spi_begin();
        spi_bits(8'hD8, 8);
        spi_bits(8'h7E, 8);
        spi_bits(8'h12, 8);
        spi_bits(8'h34, 8);
        spi_end();
        expect_result("R10", r0, c0, 1, 24'h7E1234, 8'hD8);
    endtask

    initial begin
        wait_neg(4);
        test_reset();
        rst_n = 1'b1;
        wait_neg(4);
        test_reset();
        test_sizes();
        test_no_wel();
        test_short_address();
        test_ragged();
        test_trailing_bytes();
        test_bad_opcode();
        test_restart();
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

endmodule